// File: doc/BRIEF.md
# Coherence Directory with Non-Binding Helper Reads

This block is the coherence directory of a small shared-memory system that tracks every cache line with a full presence vector. Each line is in one of three states: idle, shared or exclusive. Requests arrive over a valid/ready channel and carry a line index, the requesting node, a request kind (read, read-exclusive/upgrade, eviction) and a flag. The flag marks requests issued by a run-ahead helper thread that shares a node with the main thread. The directory answers with reply messages, invalidation messages, fetch requests to an owner and self-invalidation hints. Invalidation acknowledgements come back on a separate input and are counted down for each line.

A read from a helper thread never takes ownership away from anyone. When the line is exclusive at another node, the helper is served from memory, which may be stale, and the owner receives a hint to give the line up early. The helper's node is then noted in a per-line future-sharer vector. A later read-exclusive reply carries a hint flag whenever future sharers remain. When the line is idle or shared, a helper read is handled as a plain read that also records the node as a future sharer.

Top module: `dir_future_ctrl`

## Requirements
- R1: After reset every line is idle with no sharers and no pending work, no message output is valid, and `req_ready` is high while `ack_valid` is low.
- R2: A main-thread read (kind 0) to an idle or shared line makes the line shared, adds the requester to the sharers, and one cycle later issues a reply of kind 0 (shared data) with the hint flag clear.
- R3: A main-thread read to a line held exclusively by another node issues a fetch to the owner and a shared reply to the requester in the same cycle. The line becomes shared with both nodes as sharers. A read by the owner itself gets a reply of kind 1 and leaves the line unchanged.
- R4: A main-thread read-exclusive (kind 1) sends one invalidation message. Its node mask lists every holder except the requester, and no reply goes out in that cycle. The exclusive reply (kind 1) goes out in the cycle after the acknowledgement that brings the count to zero. When there are no other holders, the exclusive reply follows the request directly. Either way the requester becomes the sole owner.
- R5: While a line waits for acknowledgements, `req_ready` is low for that line and high for other lines. `req_ready` is low in any cycle where `ack_valid` is high. An acknowledgement for a line with nothing outstanding has no effect.
- R6: A helper read (flag set, kind 0) to a line that another node holds exclusively gets a reply of kind 2 (transparent) and, in the same cycle, a self-invalidation hint to the owner. The owner keeps exclusive ownership and the helper is not made a sharer.
- R7: A helper read to an idle or shared line gets a shared reply (kind 0), and the node becomes both a sharer and a future sharer.
- R8: The hint flag of an exclusive reply is set exactly when future sharers other than the requester are recorded at the time of the request.
- R9: A node's future-sharer bit is cleared by any request from that node's main thread and by an eviction from that node.
- R10: An eviction (kind 2) is answered with a reply of kind 3. An eviction by the exclusive owner, or by the last sharer, returns the line to idle.
- R11: A helper read-exclusive is accepted but has no effect: no message is sent and the line's state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_line | input | LW | Line index |
| req_node | input | NW | Requesting node |
| req_kind | input | 2 | 0 read, 1 read-exclusive/upgrade, 2 evict |
| req_helper | input | 1 | Request comes from the helper thread |
| ack_valid | input | 1 | One invalidation acknowledgement |
| ack_line | input | LW | Line the acknowledgement belongs to |
| rsp_valid | output | 1 | Reply message valid |
| rsp_node | output | NW | Reply destination |
| rsp_kind | output | 2 | 0 shared, 1 exclusive, 2 transparent, 3 eviction ack |
| rsp_hint | output | 1 | Future sharers exist (exclusive replies) |
| inv_valid | output | 1 | Invalidation message valid |
| inv_mask | output | NODES | Nodes to invalidate |
| fetch_valid | output | 1 | Fetch-to-owner message valid |
| fetch_node | output | NW | Owner to fetch from |
| sih_valid | output | 1 | Self-invalidation hint valid |
| sih_node | output | NW | Node receiving the hint |

## Verification
The hardest case to reach from the ports is an exclusive reply whose hint flag depends on future-sharer history. Recorded future sharers only show up on the next read-exclusive to that line, after that read-exclusive's acknowledgements have all come back. The stimulus therefore builds histories on one line step by step: a helper read against a remote owner, a second owner taking the line, a main-thread read from the helper's node, and a third read-exclusive. Each history is then probed with a read-exclusive whose hint flag and invalidation mask show what was stored. State that a helper read-exclusive might have altered is read back through the fetch or exclusive reply that the next main-thread read produces.

// File: rtl/dir_pkg.sv
`timescale 1ns/1ps
package dir_pkg;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_SHARED = 2'd1,
        LS_EXCL   = 2'd2
    } line_state_e;

    localparam logic [1:0] RQ_READ  = 2'd0;
    localparam logic [1:0] RQ_READX = 2'd1;
    localparam logic [1:0] RQ_EVICT = 2'd2;

    typedef enum logic [1:0] {
        RK_SHARED = 2'd0,
        RK_EXCL   = 2'd1,
        RK_TRANSP = 2'd2,
        RK_EVACK  = 2'd3
    } rsp_kind_e;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dir_action.sv
`timescale 1ns/1ps
module dir_action
    import dir_pkg::*;
#(
    parameter int NODES = 4,
    localparam int NW = idx_bits(NODES),
    localparam int CW = $clog2(NODES + 1),
    localparam int EW = 2 + NODES + NW + NODES + CW + NW + 1
) (
    input  logic [EW-1:0] cur,
    input  logic [NW-1:0] node,
    input  logic [1:0]    kind,
    input  logic          helper,
    output logic [EW-1:0] nxt,
    output logic          rsp_v,
    output logic [NW-1:0] rsp_node,
    output rsp_kind_e     rsp_kind,
    output logic          rsp_hint,
    output logic [NODES-1:0] inv_mask,
    output logic          fetch_v,
    output logic [NW-1:0] fetch_node,
    output logic          sih_v,
    output logic [NW-1:0] sih_node
);
    typedef struct packed {
        line_state_e      state;
        logic [NODES-1:0] sharers;
        logic [NW-1:0]    owner;
        logic [NODES-1:0] future;
        logic [CW-1:0]    pend;
        logic [NW-1:0]    pend_node;
        logic             pend_hint;
    } entry_t;

    entry_t e, ne;
    logic [NODES-1:0] self_bit, own_bit, fut_left, others;

    assign e   = cur;
    assign nxt = ne;

    always_comb begin
        ne         = e;
        rsp_v      = 1'b0;
        rsp_node   = node;
        rsp_kind   = RK_SHARED;
        rsp_hint   = 1'b0;
        inv_mask   = '0;
        fetch_v    = 1'b0;
        fetch_node = e.owner;
        sih_v      = 1'b0;
        sih_node   = e.owner;
        self_bit   = NODES'(1) << node;
        own_bit    = NODES'(1) << e.owner;
        fut_left   = e.future & ~self_bit;
        others     = '0;
        case (kind)
            RQ_READ: begin
                if (helper && e.state == LS_EXCL && e.owner != node) begin
                    // non-binding: owner untouched, only a hint
                    rsp_v     = 1'b1;
                    rsp_kind  = RK_TRANSP;
                    ne.future = e.future | self_bit;
                    sih_v     = 1'b1;
                end else begin
                    rsp_v     = 1'b1;
                    ne.future = helper ? (e.future | self_bit) : fut_left;
                    case (e.state)
                        LS_IDLE: begin
                            ne.state   = LS_SHARED;
                            ne.sharers = self_bit;
                        end
                        LS_SHARED: ne.sharers = e.sharers | self_bit;
                        default: begin
                            if (e.owner == node) begin
                                rsp_kind = RK_EXCL;
                            end else begin
                                fetch_v    = 1'b1;
                                ne.state   = LS_SHARED;
                                ne.sharers = self_bit | own_bit;
                            end
                        end
                    endcase
                end
            end
            RQ_READX: begin
                if (!helper) begin
                    others     = ((e.state == LS_EXCL) ? own_bit : e.sharers) & ~self_bit;
                    ne.state   = LS_EXCL;
                    ne.owner   = node;
                    ne.sharers = self_bit;
                    ne.future  = fut_left;
                    if (others == '0) begin
                        rsp_v    = 1'b1;
                        rsp_kind = RK_EXCL;
                        rsp_hint = |fut_left;
                    end else begin
                        inv_mask     = others;
                        ne.pend      = CW'($countones(others));
                        ne.pend_node = node;
                        ne.pend_hint = |fut_left;
                    end
                end
            end
            RQ_EVICT: begin
                rsp_v      = 1'b1;
                rsp_kind   = RK_EVACK;
                ne.future  = fut_left;
                ne.sharers = e.sharers & ~self_bit;
                if ((e.state == LS_EXCL && e.owner == node) ||
                    (e.state == LS_SHARED && (e.sharers & ~self_bit) == '0)) begin
                    ne.state   = LS_IDLE;
                    ne.sharers = '0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_table.sv
`timescale 1ns/1ps
module dir_table
    import dir_pkg::*;
#(
    parameter int LINES = 16,
    parameter int NODES = 4,
    localparam int LW = idx_bits(LINES),
    localparam int NW = idx_bits(NODES),
    localparam int CW = $clog2(NODES + 1),
    localparam int EW = 2 + NODES + NW + NODES + CW + NW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] rd_line,
    output logic [EW-1:0] rd_entry,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_line,
    input  logic [EW-1:0] wr_entry,
    input  logic          ack_valid,
    input  logic [LW-1:0] ack_line,
    output logic          done_v,
    output logic [NW-1:0] done_node,
    output logic          done_hint
);
    typedef struct packed {
        line_state_e      state;
        logic [NODES-1:0] sharers;
        logic [NW-1:0]    owner;
        logic [NODES-1:0] future;
        logic [CW-1:0]    pend;
        logic [NW-1:0]    pend_node;
        logic             pend_hint;
    } entry_t;

    entry_t mem [LINES];
    entry_t rd_e, ack_e;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        entry_t q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_line == LW'(i)) begin
                q <= wr_entry;
            end else if (ack_valid && ack_line == LW'(i) && q.pend != '0) begin
                q.pend <= q.pend - 1'b1;
            end
        end
        assign mem[i] = q;
    end

    assign rd_e      = mem[rd_line];
    assign rd_entry  = rd_e;
    assign ack_e     = mem[ack_line];
    assign done_v    = ack_valid && ack_e.pend == CW'(1);
    assign done_node = ack_e.pend_node;
    assign done_hint = ack_e.pend_hint;

    // R4
    excl_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_e.state == LS_EXCL |-> $countones(rd_e.sharers) == 1);

    // R10
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_e.state == LS_IDLE |-> rd_e.sharers == '0);
endmodule

// File: rtl/dir_future_ctrl.sv
`timescale 1ns/1ps
module dir_future_ctrl
    import dir_pkg::*;
#(
    parameter int LINES = 16,
    parameter int NODES = 4,
    localparam int LW = idx_bits(LINES),
    localparam int NW = idx_bits(NODES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LW-1:0]    req_line,
    input  logic [NW-1:0]    req_node,
    input  logic [1:0]       req_kind,
    input  logic             req_helper,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_line,
    output logic             rsp_valid,
    output logic [NW-1:0]    rsp_node,
    output logic [1:0]       rsp_kind,
    output logic             rsp_hint,
    output logic             inv_valid,
    output logic [NODES-1:0] inv_mask,
    output logic             fetch_valid,
    output logic [NW-1:0]    fetch_node,
    output logic             sih_valid,
    output logic [NW-1:0]    sih_node
);
    localparam int CW = $clog2(NODES + 1);
    localparam int EW = 2 + NODES + NW + NODES + CW + NW + 1;

    typedef struct packed {
        line_state_e      state;
        logic [NODES-1:0] sharers;
        logic [NW-1:0]    owner;
        logic [NODES-1:0] future;
        logic [CW-1:0]    pend;
        logic [NW-1:0]    pend_node;
        logic             pend_hint;
    } entry_t;

    logic [EW-1:0] rd_bits, nxt_bits;
    entry_t        rd_e;
    logic          accept;
    logic          a_rsp_v, a_rsp_hint, a_fetch_v, a_sih_v;
    logic [NW-1:0] a_rsp_node, a_fetch_node, a_sih_node;
    rsp_kind_e     a_rsp_kind;
    logic [NODES-1:0] a_inv;
    logic          done_v, done_hint;
    logic [NW-1:0] done_node;

    assign rd_e      = rd_bits;
    assign req_ready = !ack_valid && rd_e.pend == '0;
    assign accept    = req_valid && req_ready;

    dir_table #(.LINES(LINES), .NODES(NODES)) u_table (
        .clk(clk), .rst(rst),
        .rd_line(req_line), .rd_entry(rd_bits),
        .wr_en(accept), .wr_line(req_line), .wr_entry(nxt_bits),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .done_v(done_v), .done_node(done_node), .done_hint(done_hint)
    );

    dir_action #(.NODES(NODES)) u_action (
        .cur(rd_bits), .node(req_node), .kind(req_kind), .helper(req_helper),
        .nxt(nxt_bits),
        .rsp_v(a_rsp_v), .rsp_node(a_rsp_node), .rsp_kind(a_rsp_kind), .rsp_hint(a_rsp_hint),
        .inv_mask(a_inv),
        .fetch_v(a_fetch_v), .fetch_node(a_fetch_node),
        .sih_v(a_sih_v), .sih_node(a_sih_node)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_node    <= '0;
            rsp_kind    <= '0;
            rsp_hint    <= 1'b0;
            inv_valid   <= 1'b0;
            inv_mask    <= '0;
            fetch_valid <= 1'b0;
            fetch_node  <= '0;
            sih_valid   <= 1'b0;
            sih_node    <= '0;
        end else begin
            rsp_valid   <= (accept && a_rsp_v) || done_v;
            rsp_node    <= done_v ? done_node : a_rsp_node;
            rsp_kind    <= done_v ? RK_EXCL : a_rsp_kind;
            rsp_hint    <= done_v ? done_hint : a_rsp_hint;
            inv_valid   <= accept && (a_inv != '0);
            inv_mask    <= a_inv;
            fetch_valid <= accept && a_fetch_v;
            fetch_node  <= a_fetch_node;
            sih_valid   <= accept && a_sih_v;
            sih_node    <= a_sih_node;
        end
    end

    // R6
    transp_hint_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_kind == RK_TRANSP |-> sih_valid);

    // R4
    inv_holds_reply_chk: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> !rsp_valid);

    // R3
    fetch_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> rsp_valid && rsp_kind == RK_SHARED);
endmodule

// File: tb/dir_future_ctrl_test.sv
`timescale 1ns/1ps
module dir_future_ctrl_test;
    import dir_pkg::*;

    localparam int LINES = 16;
    localparam int NODES = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_helper = 1'b0, ack_valid = 1'b0;
    logic [3:0] req_line = '0, ack_line = '0;
    logic [1:0] req_node = '0, req_kind = '0;
    logic req_ready, rsp_valid, rsp_hint, inv_valid, fetch_valid, sih_valid;
    logic [1:0] rsp_node, rsp_kind, fetch_node, sih_node;
    logic [3:0] inv_mask;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [1:0] cls;   // 0 reply, 1 inval, 2 fetch, 3 hint
        logic [1:0] node;
        logic [1:0] kind;
        logic       hint;
        logic [3:0] mask;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    dir_future_ctrl #(.LINES(LINES), .NODES(NODES)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .req_node(req_node), .req_kind(req_kind), .req_helper(req_helper),
        .ack_valid(ack_valid), .ack_line(ack_line),
        .rsp_valid(rsp_valid), .rsp_node(rsp_node), .rsp_kind(rsp_kind), .rsp_hint(rsp_hint),
        .inv_valid(inv_valid), .inv_mask(inv_mask),
        .fetch_valid(fetch_valid), .fetch_node(fetch_node),
        .sih_valid(sih_valid), .sih_node(sih_node)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input item_t it, input string tag);
        exp_q.push_back(it);
        tag_q.push_back(tag);
    endtask

    task automatic exp_rsp(input logic [1:0] n, input logic [1:0] k, input logic h, input string tag);
        push('{cls: 2'd0, node: n, kind: k, hint: h, mask: 4'd0}, tag);
    endtask
    task automatic exp_inv(input logic [3:0] m, input string tag);
        push('{cls: 2'd1, node: 2'd0, kind: 2'd0, hint: 1'b0, mask: m}, tag);
    endtask
    task automatic exp_fetch(input logic [1:0] n, input string tag);
        push('{cls: 2'd2, node: n, kind: 2'd0, hint: 1'b0, mask: 4'd0}, tag);
    endtask
    task automatic exp_sih(input logic [1:0] n, input string tag);
        push('{cls: 2'd3, node: n, kind: 2'd0, hint: 1'b0, mask: 4'd0}, tag);
    endtask

    task automatic observe(input item_t got);
        item_t want;
        string tag;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R11 unexpected message actual=%h expected=none", got);
        end else begin
            want = exp_q.pop_front();
            tag  = tag_q.pop_front();
            if (got !== want) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", tag, got, want);
            end
        end
    endtask

    // monitor: outputs change only at posedge, sampled at negedge
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rsp_valid)   observe('{cls: 2'd0, node: rsp_node, kind: rsp_kind, hint: rsp_hint, mask: 4'd0});
            if (inv_valid)   observe('{cls: 2'd1, node: 2'd0, kind: 2'd0, hint: 1'b0, mask: inv_mask});
            if (fetch_valid) observe('{cls: 2'd2, node: fetch_node, kind: 2'd0, hint: 1'b0, mask: 4'd0});
            if (sih_valid)   observe('{cls: 2'd3, node: sih_node, kind: 2'd0, hint: 1'b0, mask: 4'd0});
        end
    end

    task automatic send(input int line, input int node, input logic [1:0] kind, input logic helper);
        @(negedge clk);
        req_valid  = 1'b1;
        req_line   = 4'(line);
        req_node   = 2'(node);
        req_kind   = kind;
        req_helper = helper;
        #0.5;
        while (!req_ready) begin
            @(negedge clk);
            #0.5;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int line);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_line  = 4'(line);
        #0.5;
        check(req_ready == 1'b0, "R5 ready while ack", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        // R1 reset state
        check(rsp_valid == 1'b0,   "R1 rsp_valid", int'(rsp_valid), 0);
        check(inv_valid == 1'b0,   "R1 inv_valid", int'(inv_valid), 0);
        check(fetch_valid == 1'b0, "R1 fetch_valid", int'(fetch_valid), 0);
        check(sih_valid == 1'b0,   "R1 sih_valid", int'(sih_valid), 0);
        check(req_ready == 1'b1,   "R1 req_ready", int'(req_ready), 1);

        // R2 reads to idle then shared line 3
        exp_rsp(2'd0, RK_SHARED, 1'b0, "R2 read idle");
        send(3, 0, RQ_READ, 1'b0);
        exp_rsp(2'd1, RK_SHARED, 1'b0, "R2 read shared");
        send(3, 1, RQ_READ, 1'b0);

        // R4 read-exclusive with two sharers
        exp_inv(4'b0011, "R4 inval others");
        send(3, 2, RQ_READX, 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_line = 4'd3; req_kind = RQ_READ; req_helper = 1'b0;
        #0.5;
        check(req_ready == 1'b0, "R5 pending line stalls", int'(req_ready), 0);
        req_line = 4'd4;
        #0.5;
        check(req_ready == 1'b1, "R5 other line free", int'(req_ready), 1);
        req_valid = 1'b0;
        ack(3);
        exp_rsp(2'd2, RK_EXCL, 1'b0, "R4 reply after last ack");
        ack(3);

        // R6 helper read vs remote owner
        exp_rsp(2'd1, RK_TRANSP, 1'b0, "R6 transparent reply");
        exp_sih(2'd2, "R6 hint to owner");
        send(3, 1, RQ_READ, 1'b1);

        // R8 hint carried; R6 owner still sole holder
        exp_inv(4'b0100, "R6 only owner invalidated");
        send(3, 3, RQ_READX, 1'b0);
        exp_rsp(2'd3, RK_EXCL, 1'b1, "R8 hint set");
        ack(3);

        // R3 read to exclusive line; R9 main read clears node1 future
        exp_rsp(2'd1, RK_SHARED, 1'b0, "R3 shared reply");
        exp_fetch(2'd3, "R3 fetch owner");
        send(3, 1, RQ_READ, 1'b0);
        exp_inv(4'b1010, "R3 both now sharers");
        send(3, 0, RQ_READX, 1'b0);
        ack(3);
        exp_rsp(2'd0, RK_EXCL, 1'b0, "R9 main request cleared future");
        ack(3);

        // R7 helper read to idle line 5
        exp_rsp(2'd2, RK_SHARED, 1'b0, "R7 upgraded read");
        send(5, 2, RQ_READ, 1'b1);
        exp_inv(4'b0100, "R7 helper is sharer");
        send(5, 0, RQ_READX, 1'b0);
        exp_rsp(2'd0, RK_EXCL, 1'b1, "R7 helper is future sharer");
        ack(5);

        // R9 eviction clears future bit
        exp_rsp(2'd2, RK_EVACK, 1'b0, "R10 evict ack");
        send(5, 2, RQ_EVICT, 1'b0);
        exp_inv(4'b0001, "R4 inval owner");
        send(5, 1, RQ_READX, 1'b0);
        exp_rsp(2'd1, RK_EXCL, 1'b0, "R9 evict cleared future");
        ack(5);

        // R11 helper read-exclusive ignored: owner still node1
        send(5, 3, RQ_READX, 1'b1);
        exp_rsp(2'd3, RK_SHARED, 1'b0, "R11 state unchanged");
        exp_fetch(2'd1, "R11 owner unchanged");
        send(5, 3, RQ_READ, 1'b0);

        // R10 owner eviction to idle
        exp_rsp(2'd0, RK_EXCL, 1'b0, "R4 no holders immediate");
        send(7, 0, RQ_READX, 1'b0);
        exp_rsp(2'd0, RK_EVACK, 1'b0, "R10 owner evict ack");
        send(7, 0, RQ_EVICT, 1'b0);
        exp_rsp(2'd1, RK_EXCL, 1'b0, "R10 line idle after owner evict");
        send(7, 1, RQ_READX, 1'b0);

        // R10 last sharer eviction
        exp_rsp(2'd2, RK_SHARED, 1'b0, "R2 read line 9");
        send(9, 2, RQ_READ, 1'b0);
        exp_rsp(2'd2, RK_EVACK, 1'b0, "R10 sharer evict ack");
        send(9, 2, RQ_EVICT, 1'b0);
        exp_rsp(2'd3, RK_EXCL, 1'b0, "R10 idle after last sharer");
        send(9, 3, RQ_READX, 1'b0);

        // R5 stray ack ignored
        ack(11);
        exp_rsp(2'd0, RK_SHARED, 1'b0, "R5 stray ack no stall");
        send(11, 0, RQ_READ, 1'b0);

        // R7 helper read to shared line, R8 hint from it
        exp_rsp(2'd0, RK_SHARED, 1'b0, "R2 read line 12");
        send(12, 0, RQ_READ, 1'b0);
        exp_rsp(2'd1, RK_SHARED, 1'b0, "R7 helper on shared line");
        send(12, 1, RQ_READ, 1'b1);
        exp_inv(4'b0011, "R7 helper added as sharer");
        send(12, 2, RQ_READX, 1'b0);
        ack(12);
        exp_rsp(2'd2, RK_EXCL, 1'b1, "R8 hint from helper on shared line");
        ack(12);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected messages seen", exp_q.size(), 0);
        finish_run();
    end
endmodule